// File: doc/BRIEF.md
# Row-Stationary 1-D Convolution Processing Element

This processing element computes one output row of a 1-D convolution. A row of S filter weights is written once into a small local register file and held there for the whole row, and may be kept for later rows. Input activations arrive one at a time. A local window of S activations slides across the input row by a stride of U. For every window position the element runs S sequential multiply-accumulate steps and emits one partial sum. A row of W activations yields F = (W − S)/U + 1 partial sums.

Weights, activations, incoming partial sums and outgoing partial sums each pass through a small FIFO with a valid/ready handshake. The element therefore stalls cleanly when a source runs dry or the consumer holds it off. A column of elements working on different filter rows can be chained into a 2-D convolution. To do this, enable the partial-sum input: each output then starts from the value taken from the incoming partial-sum stream instead of zero. S, W, U, the chaining enable and the weight-reload choice are sampled when a run starts. An illegal setting is refused with an error flag.

Top module: `rs_conv_pe`

## Requirements
- R1: After reset, busy_o, done_o, err_o and pout_valid_o are 0, and wgt_ready_o, act_ready_o and pin_ready_o are 1.
- R2: Output j of a run equals the sum over k = 0..S−1 of weight[k] × activation[j·U + k]. Weights and activations are signed two's complement of DATA_W bits. weight[k] is the k-th weight accepted, and activation[i] is the i-th activation accepted in that run. The sum wraps to ACC_W bits.
- R3: A run with valid settings emits exactly F = (W − S)/U + 1 partial sums in ascending j, and no further output appears.
- R4: With psum_en_i = 1 at start, each output j is seeded with the j-th value accepted on the partial-sum input, and that value is added (modulo 2^ACC_W) to the R2 sum. With psum_en_i = 0, no partial-sum input is consumed.
- R5: With reload_i = 1 at start, the run first accepts S new weights. With reload_i = 0, it accepts none and reuses the weights held from the previous load.
- R6: Starved inputs or a held-off output lose or duplicate no data. While pout_valid_o = 1 and pout_ready_i = 0, pout_valid_o stays 1 and pout_data_o stays unchanged.
- R7: done_o rises in the cycle busy_o falls at the end of a run, once the last output has entered the output FIFO. It stays 1 with busy_o = 0 until the next start.
- R8: A start with S = 0, S > MAX_S, U = 0, W < S, W > MAX_W, or (W − S) not a multiple of U sets err_o = 1 and leaves busy_o = 0, done_o = 0 and no output. The next valid start clears err_o.
- R9: start_i and the configuration inputs are ignored while busy_o = 1. The run in progress continues with the values sampled at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a row run (sampled when idle) |
| reload_i | input | 1 | 1: load S new weights before the run |
| psum_en_i | input | 1 | 1: seed each output from the partial-sum input |
| cfg_s_i | input | $clog2(MAX_S+1) | Filter row length S |
| cfg_w_i | input | $clog2(MAX_W+1) | Input row length W |
| cfg_u_i | input | $clog2(MAX_S+1) | Stride U |
| wgt_valid_i | input | 1 | Weight valid |
| wgt_ready_o | output | 1 | Weight FIFO has space |
| wgt_data_i | input | DATA_W | Signed weight |
| act_valid_i | input | 1 | Activation valid |
| act_ready_o | output | 1 | Activation FIFO has space |
| act_data_i | input | DATA_W | Signed activation |
| pin_valid_i | input | 1 | Incoming partial sum valid |
| pin_ready_o | output | 1 | Incoming partial-sum FIFO has space |
| pin_data_i | input | ACC_W | Incoming partial sum |
| pout_valid_o | output | 1 | Outgoing partial sum valid |
| pout_ready_i | input | 1 | Consumer accepts outgoing partial sum |
| pout_data_o | output | ACC_W | Outgoing partial sum |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run completed |
| err_o | output | 1 | Last start was refused |

## Verification
A misaligned activation window or a wrong weight index shows at the ports as a wrong partial-sum value. This appears at the first output that uses the bad entry: within S + U + 3 cycles of the fault once the inputs are flowing. A fault in the consumed-activation counter or the stride counter shows as a missing or extra output, or as a run that never ends. The random mix of strides, row lengths, input gaps and output back-pressure exposes these on the very next row. A fault in the seed path shows on the first chained output.

// File: rtl/rs_pe_pkg.sv
package rs_pe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOADW,
    ST_FILL,
    ST_SEED,
    ST_MAC,
    ST_PUSH,
    ST_SLIDE
  } pe_state_e;
endpackage

// File: rtl/rs_sync_fifo.sv
module rs_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [AW:0]      cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rs_pe_window.sv
// Indexed register file with optional shift-in at a runtime length.
module rs_pe_window #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(DEPTH)-1:0]   wr_idx_i,
  input  logic                       shift_en_i,
  input  logic [$clog2(DEPTH+1)-1:0] len_i,
  input  logic [WIDTH-1:0]           din_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
  output logic [WIDTH-1:0]           dout_o
);
  localparam int IW = $clog2(DEPTH);

  logic [WIDTH-1:0] ent_q [DEPTH];
  logic [WIDTH-1:0] nb    [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_nb
    if (g < DEPTH - 1) begin : g_mid
      assign nb[g] = ent_q[g+1];
    end else begin : g_end
      assign nb[g] = din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en_i && (wr_idx_i == IW'(i))) ent_q[i] <= din_i;
        else if (shift_en_i && ((i + 1) < int'(len_i))) ent_q[i] <= nb[i];
        else if (shift_en_i && ((i + 1) == int'(len_i))) ent_q[i] <= din_i;
      end
    end
  end

  assign dout_o = ent_q[rd_idx_i];
endmodule

// File: rtl/rs_pe_mac.sv
module rs_pe_mac #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_en_i,
  input  logic [ACC_W-1:0]  seed_i,
  input  logic              step_en_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int PW = 2 * DATA_W;

  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_ext;

  assign prod     = $signed(a_i) * $signed(b_i);
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_o <= '0;
    else if (seed_en_i) acc_o <= seed_i;
    else if (step_en_i) acc_o <= acc_o + prod_ext;
  end
endmodule

// File: rtl/rs_conv_pe.sv
module rs_conv_pe
  import rs_pe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 24,
  parameter int MAX_S      = 8,
  parameter int MAX_W      = 64,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         reload_i,
  input  logic                         psum_en_i,
  input  logic [$clog2(MAX_S+1)-1:0]   cfg_s_i,
  input  logic [$clog2(MAX_W+1)-1:0]   cfg_w_i,
  input  logic [$clog2(MAX_S+1)-1:0]   cfg_u_i,
  input  logic                         wgt_valid_i,
  output logic                         wgt_ready_o,
  input  logic [DATA_W-1:0]            wgt_data_i,
  input  logic                         act_valid_i,
  output logic                         act_ready_o,
  input  logic [DATA_W-1:0]            act_data_i,
  input  logic                         pin_valid_i,
  output logic                         pin_ready_o,
  input  logic [ACC_W-1:0]             pin_data_i,
  output logic                         pout_valid_o,
  input  logic                         pout_ready_i,
  output logic [ACC_W-1:0]             pout_data_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         err_o
);
  localparam int SW = $clog2(MAX_S + 1);
  localparam int WW = $clog2(MAX_W + 1);
  localparam int KW = $clog2(MAX_S);

  pe_state_e       state_q;
  logic [SW-1:0]   s_q, u_q, slide_q;
  logic [WW-1:0]   w_q, taken_q;
  logic [KW-1:0]   idx_q;
  logic            pen_q, done_q, err_q;

  logic            wgt_full, wgt_empty, act_full, act_empty;
  logic            pin_full, pin_empty, pout_full, pout_empty;
  logic [DATA_W-1:0] wgt_head, act_head, wgt_rd, act_rd;
  logic [ACC_W-1:0]  pin_head, acc;
  logic            wgt_pop, act_pop, pin_pop, pout_push;
  logic            idx_last, slide_last, seed_go, cfg_bad;
  logic [WW-1:0]   span;

  // Edge FIFOs
  rs_sync_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_wgt_fifo (
    .clk_i, .rst_ni, .push_i(wgt_valid_i), .wdata_i(wgt_data_i), .full_o(wgt_full),
    .pop_i(wgt_pop), .rdata_o(wgt_head), .empty_o(wgt_empty));
  rs_sync_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_act_fifo (
    .clk_i, .rst_ni, .push_i(act_valid_i), .wdata_i(act_data_i), .full_o(act_full),
    .pop_i(act_pop), .rdata_o(act_head), .empty_o(act_empty));
  rs_sync_fifo #(.WIDTH(ACC_W), .DEPTH(FIFO_DEPTH)) u_pin_fifo (
    .clk_i, .rst_ni, .push_i(pin_valid_i), .wdata_i(pin_data_i), .full_o(pin_full),
    .pop_i(pin_pop), .rdata_o(pin_head), .empty_o(pin_empty));
  rs_sync_fifo #(.WIDTH(ACC_W), .DEPTH(FIFO_DEPTH)) u_pout_fifo (
    .clk_i, .rst_ni, .push_i(pout_push), .wdata_i(acc), .full_o(pout_full),
    .pop_i(pout_ready_i), .rdata_o(pout_data_o), .empty_o(pout_empty));

  assign wgt_ready_o  = !wgt_full;
  assign act_ready_o  = !act_full;
  assign pin_ready_o  = !pin_full;
  assign pout_valid_o = !pout_empty;

  // Stationary weight row and sliding activation window
  rs_pe_window #(.WIDTH(DATA_W), .DEPTH(MAX_S)) u_wgt_rf (
    .clk_i, .rst_ni, .wr_en_i(wgt_pop), .wr_idx_i(idx_q), .shift_en_i(1'b0),
    .len_i(s_q), .din_i(wgt_head), .rd_idx_i(idx_q), .dout_o(wgt_rd));
  rs_pe_window #(.WIDTH(DATA_W), .DEPTH(MAX_S)) u_act_win (
    .clk_i, .rst_ni, .wr_en_i(act_pop && (state_q == ST_FILL)), .wr_idx_i(idx_q),
    .shift_en_i(act_pop && (state_q == ST_SLIDE)), .len_i(s_q), .din_i(act_head),
    .rd_idx_i(idx_q), .dout_o(act_rd));

  rs_pe_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni, .seed_en_i(seed_go), .seed_i(pen_q ? pin_head : '0),
    .step_en_i(state_q == ST_MAC), .a_i(wgt_rd), .b_i(act_rd), .acc_o(acc));

  assign wgt_pop    = (state_q == ST_LOADW) && !wgt_empty;
  assign act_pop    = ((state_q == ST_FILL) || (state_q == ST_SLIDE)) && !act_empty;
  assign seed_go    = (state_q == ST_SEED) && (!pen_q || !pin_empty);
  assign pin_pop    = seed_go && pen_q;
  assign pout_push  = (state_q == ST_PUSH) && !pout_full;
  assign idx_last   = (SW'(idx_q) == s_q - 1'b1);
  assign slide_last = (slide_q == u_q - 1'b1);

  // Setting check: window must fit and the stride must land on the row end
  assign span = cfg_w_i - WW'(cfg_s_i);
  always_comb begin
    cfg_bad = 1'b0;
    if (cfg_s_i == '0 || cfg_s_i > SW'(MAX_S) || cfg_u_i == '0 ||
        cfg_w_i < WW'(cfg_s_i) || cfg_w_i > WW'(MAX_W))
      cfg_bad = 1'b1;
    else if ((span % WW'(cfg_u_i)) != '0)
      cfg_bad = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      s_q     <= '0;
      u_q     <= '0;
      w_q     <= '0;
      pen_q   <= 1'b0;
      idx_q   <= '0;
      slide_q <= '0;
      taken_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          s_q     <= cfg_s_i;
          u_q     <= cfg_u_i;
          w_q     <= cfg_w_i;
          pen_q   <= psum_en_i;
          idx_q   <= '0;
          taken_q <= '0;
          done_q  <= 1'b0;
          err_q   <= cfg_bad;
          if (!cfg_bad) state_q <= reload_i ? ST_LOADW : ST_FILL;
        end
        ST_LOADW: if (wgt_pop) begin
          idx_q <= idx_last ? '0 : idx_q + 1'b1;
          if (idx_last) state_q <= ST_FILL;
        end
        ST_FILL: if (act_pop) begin
          taken_q <= taken_q + 1'b1;
          idx_q   <= idx_last ? '0 : idx_q + 1'b1;
          if (idx_last) state_q <= ST_SEED;
        end
        ST_SEED: if (seed_go) begin
          idx_q   <= '0;
          state_q <= ST_MAC;
        end
        ST_MAC: begin
          idx_q <= idx_last ? '0 : idx_q + 1'b1;
          if (idx_last) state_q <= ST_PUSH;
        end
        ST_PUSH: if (pout_push) begin
          slide_q <= '0;
          if (taken_q == w_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_SLIDE;
          end
        end
        ST_SLIDE: if (act_pop) begin
          taken_q <= taken_q + 1'b1;
          slide_q <= slide_q + 1'b1;
          if (slide_last) state_q <= ST_SEED;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/rs_conv_pe_chk.sv
module rs_conv_pe_chk #(
  parameter int ACC_W = 24,
  parameter int SW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             pout_valid_o,
  input logic             pout_ready_i,
  input logic [ACC_W-1:0] pout_data_o,
  input logic [SW-1:0]    s_q
);
  p_pout_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pout_valid_o && !pout_ready_i) |=> (pout_valid_o && $stable(pout_data_o)));

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !done_o));

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(s_q));
endmodule

bind rs_conv_pe rs_conv_pe_chk #(.ACC_W(ACC_W), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .pout_valid_o(pout_valid_o),
  .pout_ready_i(pout_ready_i), .pout_data_o(pout_data_o), .s_q(s_q));

// File: tb/rs_conv_pe_bench.sv
`timescale 1ns/1ps
module rs_conv_pe_bench;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 24;
  localparam int MAX_S  = 8;
  localparam int MAX_W  = 64;
  localparam int SW     = $clog2(MAX_S + 1);
  localparam int WW     = $clog2(MAX_W + 1);
  localparam int MASK   = (1 << ACC_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, reload_i = 1'b0, psum_en_i = 1'b0;
  logic [SW-1:0] cfg_s_i = '0, cfg_u_i = '0;
  logic [WW-1:0] cfg_w_i = '0;
  logic wgt_valid_i = 1'b0, act_valid_i = 1'b0, pin_valid_i = 1'b0, pout_ready_i = 1'b0;
  logic [DATA_W-1:0] wgt_data_i = '0, act_data_i = '0;
  logic [ACC_W-1:0]  pin_data_i = '0;
  logic wgt_ready_o, act_ready_o, pin_ready_o, pout_valid_o, busy_o, done_o, err_o;
  logic [ACC_W-1:0] pout_data_o;

  always #10 clk_i = ~clk_i;

  rs_conv_pe u_rs_conv_pe (
    .clk_i, .rst_ni, .start_i, .reload_i, .psum_en_i, .cfg_s_i, .cfg_w_i, .cfg_u_i,
    .wgt_valid_i, .wgt_ready_o, .wgt_data_i, .act_valid_i, .act_ready_o, .act_data_i,
    .pin_valid_i, .pin_ready_o, .pin_data_i, .pout_valid_o, .pout_ready_i, .pout_data_o,
    .busy_o, .done_o, .err_o);

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int wgt_m [MAX_S];
  int act_m [MAX_W];
  int pin_m [MAX_W];
  int exp_m [MAX_W];

  task automatic check(input bit ok, input string req, input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, expv, expv);
    end
  endtask

  function automatic int expect_out(input int j, input int s, input int u, input bit pen);
    int sum = pen ? pin_m[j] : 0;
    for (int k = 0; k < s; k++) sum += wgt_m[k] * act_m[j*u + k];
    return sum & MASK;
  endfunction

  task automatic feed_w(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk_i);
      @(negedge clk_i);
      wgt_valid_i = 1'b1; wgt_data_i = 8'(wgt_m[i]);
      while (!wgt_ready_o) @(negedge clk_i);
      @(posedge clk_i); #1 wgt_valid_i = 1'b0;
    end
  endtask

  task automatic feed_a(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk_i);
      @(negedge clk_i);
      act_valid_i = 1'b1; act_data_i = 8'(act_m[i]);
      while (!act_ready_o) @(negedge clk_i);
      @(posedge clk_i); #1 act_valid_i = 1'b0;
    end
  endtask

  task automatic feed_p(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk_i);
      @(negedge clk_i);
      pin_valid_i = 1'b1; pin_data_i = 24'(pin_m[i]);
      while (!pin_ready_o) @(negedge clk_i);
      @(posedge clk_i); #1 pin_valid_i = 1'b0;
    end
  endtask

  task automatic consume(input int f, input string tag);
    int j = 0;
    bit held = 1'b0;
    int held_v = 0;
    while (j < f) begin
      @(negedge clk_i);
      if (held)
        check(pout_valid_o && (int'(pout_data_o) == held_v),
              {"R6 held output stable ", tag}, int'(pout_data_o), held_v);
      held = 1'b0;
      pout_ready_i = ($urandom_range(0, 3) != 0);
      if (pout_valid_o) begin
        if (pout_ready_i) begin
          check(int'(pout_data_o) == exp_m[j], {"R2/R4 output value ", tag},
                int'(pout_data_o), exp_m[j]);
          j++;
        end else begin
          held = 1'b1; held_v = int'(pout_data_o);
        end
      end
    end
    @(posedge clk_i); #1 pout_ready_i = 1'b0;
  endtask

  // R9: a start pulse with other settings while busy must be ignored
  task automatic poke_start();
    repeat (4) @(negedge clk_i);
    if (busy_o) begin
      start_i = 1'b1; cfg_s_i = 4'd2; cfg_w_i = 7'd3; cfg_u_i = 4'd1; reload_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
  endtask

  task automatic run_conv(input int s, input int w, input int u, input bit pen,
                          input bit rl, input string tag);
    int f = (w - s) / u + 1;
    int t = 0;
    if (rl) for (int k = 0; k < s; k++) wgt_m[k] = $urandom_range(0, 255) - 128;
    for (int i = 0; i < w; i++) act_m[i] = $urandom_range(0, 255) - 128;
    for (int j = 0; j < f; j++) pin_m[j] = $urandom_range(0, MASK);
    for (int j = 0; j < f; j++) exp_m[j] = expect_out(j, s, u, pen);
    @(negedge clk_i);
    cfg_s_i = SW'(s); cfg_w_i = WW'(w); cfg_u_i = SW'(u);
    psum_en_i = pen; reload_i = rl; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, {"R7 busy after start ", tag}, busy_o, 1);
    check(done_o == 1'b0, {"R7 done cleared by start ", tag}, done_o, 0);
    fork
      begin if (rl) feed_w(s); end
      feed_a(w);
      begin if (pen) feed_p(f); end
      consume(f, tag);
      poke_start();
    join
    while (!done_o && t < 200) begin @(negedge clk_i); t++; end
    check(done_o == 1'b1, {"R7 done after last output ", tag}, done_o, 1);
    check(busy_o == 1'b0, {"R7 idle when done ", tag}, busy_o, 0);
    check(err_o == 1'b0, {"R8 no error on valid run ", tag}, err_o, 0);
    @(negedge clk_i);
    check(pout_valid_o == 1'b0, {"R3 no extra output ", tag}, pout_valid_o, 0);
  endtask

  task automatic err_case(input int s, input int w, input int u, input string tag);
    @(negedge clk_i);
    cfg_s_i = SW'(s); cfg_w_i = WW'(w); cfg_u_i = SW'(u);
    reload_i = 1'b1; psum_en_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    check(err_o == 1'b1, {"R8 error flag ", tag}, err_o, 1);
    check(busy_o == 1'b0, {"R8 stays idle ", tag}, busy_o, 0);
    check(done_o == 1'b0, {"R8 no done ", tag}, done_o, 0);
    check(pout_valid_o == 1'b0, {"R8 no output ", tag}, pout_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R7 watchdog expired: got busy=%0d expected run completion", busy_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(done_o == 1'b0, "R1 done", done_o, 0);
    check(err_o == 1'b0, "R1 err", err_o, 0);
    check(pout_valid_o == 1'b0, "R1 pout_valid", pout_valid_o, 0);
    check(wgt_ready_o && act_ready_o && pin_ready_o, "R1 input readies", 0, 1);

    run_conv(3, 5, 1, 1'b0, 1'b1, "R3 base S3 W5 U1");
    run_conv(3, 5, 1, 1'b1, 1'b0, "R4 chained, R5 weights kept");
    run_conv(1, 1, 1, 1'b0, 1'b1, "R3 single tap");
    run_conv(8, 64, 1, 1'b1, 1'b1, "R2 full size");
    run_conv(3, 9, 3, 1'b0, 1'b0, "R3 stride equals S");
    run_conv(5, 5, 7, 1'b1, 1'b1, "R3 stride beyond span");
    run_conv(2, 10, 4, 1'b0, 1'b1, "R3 stride above S");

    err_case(3, 6, 2, "r8_rem");
    err_case(0, 4, 1, "r8_s0");
    err_case(3, 6, 0, "r8_u0");
    err_case(5, 4, 1, "r8_w_lt_s");
    err_case(9, 20, 1, "r8_s_big");
    run_conv(4, 10, 2, 1'b1, 1'b0, "R8 cleared, R5 weights kept over error");

    for (int n = 0; n < 20; n++) begin
      int s = $urandom_range(1, MAX_S);
      int u = $urandom_range(1, 4);
      int w = s + u * $urandom_range(0, (MAX_W - s) / u);
      run_conv(s, w, u, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule